// File: doc/BRIEF.md
# Three-Stage Prioritised Memory Request Arbiter

This block chooses which bus master's request is handed next to an SDRAM controller. Each master holds a request line high until it sees a one-cycle grant pulse. A 3-bit priority level, set per master, places that request in one of five groups. Each group runs its own round-robin selection and keeps its winner in a single-entry holding slot. A second stage picks one holding slot and moves its master into a single committed slot. A third stage lets the committed access go to the controller only when the controller reports ready and no refresh is waiting. Refresh always goes first.

Because the stages form a pipeline, the issue order is fixed. A pending refresh goes first. The committed access goes next. Then comes whichever winner was promoted behind it, and after that the winners that groups enqueue later. A top-level request that arrives late therefore waits behind the access already committed. It does not have to wait for winners still sitting in other groups. The block only chooses the order. Command sequencing, data and SDRAM timing belong to the controller.

Top module: `mem_req_arbiter`

## Requirements
- R1: While reset is held and in the cycles after it with no request, `grant` is all zero and `issue_valid` is 0.
- R2: While `ref_req` is 1, no access issues and `ref_ack` equals `mc_ready`. The committed access keeps its slot and issues once `ref_req` falls.
- R3: While `mc_ready` is 0, no access issues and the committed master stays unchanged. It issues in the first cycle that `mc_ready` is 1.
- R4: In an issue cycle, `grant` has exactly one bit set, at position `issue_id`, and `issue_valid` is 1. In every other cycle `grant` is zero.
- R5: Level 0 is the top level. Group mapping when `split_top` is 0: level 0 goes to G0, levels 1, 2 and 3 go to G1, G2 and G3, and levels 4 to 7 go to G4. When `split_top` is 1: level-0 masters with index below N/2 go to G0, level-0 masters with index N/2 or above go to G4, and levels 4 to 7 go to G3.
- R6: The second stage ranks G0 first. When `split_top` is 1, G4 comes next, as a top group. The remaining groups follow in ascending index order.
- R7: Within a group, selection is round-robin starting at a pointer. After reset the pointer is 0, and after each pick it moves to the index after the master just picked.
- R8: A top-level request that arrives while another access is committed issues after that committed access. It issues before lower-level winners that are still queued.
- R9: On an idle arbiter, a request raised in a cycle produces its grant in the cycle that follows the second rising edge after the request was raised.
- R10: Each asserted request gets exactly one grant, and the same master is never granted in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Per-master request, held until granted |
| lvl_cfg | input | 3*N | Per-master priority level, master m at bits [3m+2:3m] |
| split_top | input | 1 | 1 makes G4 a second top-level group |
| ref_req | input | 1 | Refresh request from the controller |
| ref_ack | output | 1 | Refresh accepted this cycle |
| mc_ready | input | 1 | Controller can accept an operation |
| grant | output | N | One-cycle grant pulse to the master issued |
| issue_valid | output | 1 | An access is issued this cycle |
| issue_id | output | log2(N) | Index of the master issued |

## Verification
A sweep covers every ordered pair of masters with every pair of levels under both `split_top` settings, and the grant order is compared against a ranking computed in the bench. This separates group mapping and group ranking from same-group round-robin. A single-request sweep over every master and level pins down the pipeline latency. Directed patterns cover the remaining behaviour: a stalled controller, a refresh held over a committed access, a top request arriving behind a committed access and a queued peer, and a full set of eight same-level requests that shows pointer rotation and the absence of repeated grants.

// File: rtl/mra_pkg.sv
package mra_pkg;
  localparam int unsigned LVL_W = 3;
  localparam int unsigned NGRP  = 5;
  localparam int unsigned GW    = 3;

  // Maps a master's level to its stage-one group.
  function automatic logic [GW-1:0] group_of(input logic [LVL_W-1:0] lvl,
                                             input logic split,
                                             input logic upper_half);
    if (lvl == '0) return (split && upper_half) ? GW'(4) : GW'(0);
    if (lvl < LVL_W'(4)) return GW'(lvl);
    return split ? GW'(3) : GW'(4);
  endfunction

  // Stage-two ranking: returns {found, group index}.
  function automatic logic [GW:0] stage2_pick(input logic [NGRP-1:0] v,
                                              input logic split);
    logic [GW:0] r;
    r = '0;
    if (v[0]) r = {1'b1, GW'(0)};
    else if (split && v[NGRP-1]) r = {1'b1, GW'(NGRP-1)};
    else begin
      for (int g = NGRP-1; g >= 1; g--) begin
        if (v[g]) r = {1'b1, GW'(g)};
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/mra_group_slot.sv
module mra_group_slot #(
  parameter int N   = 8,
  parameter int IDW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   cand,
  input  logic           pop,
  output logic           q_v,
  output logic [IDW-1:0] q_id
);
  logic [IDW-1:0] ptr;
  logic           found;
  logic [IDW-1:0] win;
  logic           push;

  // Round-robin search starting at p; returns {found, index}.
  function automatic logic [IDW:0] rr_pick(input logic [N-1:0] m,
                                           input logic [IDW-1:0] p);
    logic [IDW:0] r;
    int idx;
    r = '0;
    for (int k = N-1; k >= 0; k--) begin
      idx = (int'(p) + k) % N;
      if (m[idx]) r = {1'b1, IDW'(idx)};
    end
    return r;
  endfunction

  assign {found, win} = rr_pick(cand, ptr);
  assign push = !q_v && found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v  <= 1'b0;
      q_id <= '0;
      ptr  <= '0;
    end else begin
      if (pop) q_v <= 1'b0;
      if (push) begin
        q_v  <= 1'b1;
        q_id <= win;
        ptr  <= (int'(win) == N-1) ? '0 : win + IDW'(1);
      end
    end
  end

  assert_q_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_v && !pop |=> q_v && $stable(q_id));
  assert_ptr_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> ptr != $past(win));
  assert_pop_needs_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> q_v);
endmodule

// File: rtl/mra_commit_stage.sv
module mra_commit_stage #(
  parameter int IDW = 3,
  parameter int NG  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NG-1:0]          q_v,
  input  logic [NG-1:0][IDW-1:0] q_id,
  input  logic                   split_top,
  input  logic                   mc_ready,
  input  logic                   ref_req,
  output logic                   commit_v,
  output logic [IDW-1:0]         commit_id,
  output logic                   issue,
  output logic                   ref_ack,
  output logic [NG-1:0]          pop
);
  import mra_pkg::*;

  logic          found;
  logic [GW-1:0] sel;
  logic          slot_free;
  logic          promote;

  assign {found, sel} = stage2_pick(q_v, split_top);
  assign issue     = commit_v && mc_ready && !ref_req;
  assign ref_ack   = ref_req && mc_ready;
  assign slot_free = !commit_v || issue;
  assign promote   = slot_free && found;

  always_comb begin
    pop = '0;
    if (promote) pop[sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_v  <= 1'b0;
      commit_id <= '0;
    end else begin
      if (issue) commit_v <= 1'b0;
      if (promote) begin
        commit_v  <= 1'b1;
        commit_id <= q_id[sel];
      end
    end
  end

  assert_refresh_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && commit_v |=> commit_v && $stable(commit_id));
  assert_ready_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_ready && commit_v |=> commit_v && $stable(commit_id));
  assert_top_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_free && q_v[0] |-> pop[0]);
  assert_single_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));
endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter #(
  parameter int N = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N-1:0]                req,
  input  logic [N*mra_pkg::LVL_W-1:0] lvl_cfg,
  input  logic                        split_top,
  input  logic                        ref_req,
  output logic                        ref_ack,
  input  logic                        mc_ready,
  output logic [N-1:0]                grant,
  output logic                        issue_valid,
  output logic [((N>1)?$clog2(N):1)-1:0] issue_id
);
  import mra_pkg::*;
  localparam int IDW = (N > 1) ? $clog2(N) : 1;
  localparam int NG  = NGRP;

  logic [N-1:0][GW-1:0]  mgrp;
  logic [N-1:0]          held;
  logic [NG-1:0][N-1:0]  cand;
  logic [NG-1:0]         q_v;
  logic [NG-1:0][IDW-1:0] q_id;
  logic [NG-1:0]         pop;
  logic                  commit_v;
  logic [IDW-1:0]        commit_id;
  logic                  issue;

  for (genvar m = 0; m < N; m++) begin : g_map
    assign mgrp[m] = group_of(lvl_cfg[m*LVL_W +: LVL_W], split_top, m >= N/2);
  end

  // Masters already sitting in a slot are kept out of stage one.
  always_comb begin
    held = '0;
    for (int g = 0; g < NG; g++) begin
      if (q_v[g]) held[q_id[g]] = 1'b1;
    end
    if (commit_v) held[commit_id] = 1'b1;
  end

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      for (int m = 0; m < N; m++) begin
        cand[g][m] = req[m] && !held[m] && (mgrp[m] == GW'(g));
      end
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    mra_group_slot #(.N(N), .IDW(IDW)) u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .cand (cand[g]),
      .pop  (pop[g]),
      .q_v  (q_v[g]),
      .q_id (q_id[g])
    );
  end

  mra_commit_stage #(.IDW(IDW), .NG(NG)) u_commit (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_v      (q_v),
    .q_id     (q_id),
    .split_top(split_top),
    .mc_ready (mc_ready),
    .ref_req  (ref_req),
    .commit_v (commit_v),
    .commit_id(commit_id),
    .issue    (issue),
    .ref_ack  (ref_ack),
    .pop      (pop)
  );

  always_comb begin
    grant = '0;
    if (issue) grant[commit_id] = 1'b1;
  end
  assign issue_valid = issue;
  assign issue_id    = commit_id;

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !(issue_valid && issue_id == $past(issue_id)));
  assert_ref_blocks_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> !issue_valid);
endmodule

// File: tb/sim_mem_req_arbiter.sv
`timescale 1ns/1ps
module sim_mem_req_arbiter;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] req;
  logic [N*3-1:0] lvl_cfg;
  logic split_top, ref_req, ref_ack, mc_ready, issue_valid;
  logic [N-1:0] grant;
  logic [2:0] issue_id;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  mem_req_arbiter #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .lvl_cfg(lvl_cfg),
    .split_top(split_top), .ref_req(ref_req), .ref_ack(ref_ack),
    .mc_ready(mc_ready), .grant(grant), .issue_valid(issue_valid),
    .issue_id(issue_id)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bench_group(input int lv, input bit sp, input int m);
    if (lv == 0) return (sp && m >= N/2) ? 4 : 0;
    if (lv < 4) return lv;
    return sp ? 3 : 4;
  endfunction

  function automatic int bench_rank(input int grp, input bit sp);
    if (grp == 0) return 0;
    if (sp && grp == 4) return 1;
    return grp + 1;
  endfunction

  task automatic set_lvl(input int m, input int v);
    lvl_cfg[m*3 +: 3] = 3'(v);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; req = '0; ref_req = 1'b0; mc_ready = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  // Waits for the next grant, checks R4 on it, then drops that request.
  task automatic wait_grant(output int id);
    id = -1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (grant != '0) begin
        for (int b = 0; b < N; b++) if (grant[b]) id = b;
        chk(issue_valid && $onehot(grant) && int'(issue_id) == id,
            "R4 grant/issue agreement", int'(issue_id), id);
        break;
      end
    end
    if (id >= 0) begin
      @(posedge clk); #1;
      req[id] = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int id, first, second, ea, eb;
    rst_n = 1'b0; req = '0; ref_req = 1'b0; mc_ready = 1'b1;
    split_top = 1'b0; lvl_cfg = '0;
    @(negedge clk);
    chk(grant == '0 && !issue_valid, "R1 during reset", int'(grant), 0);
    do_reset();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(grant == '0 && !issue_valid, "R1 idle after reset", int'(grant), 0);
    end

    // R9 latency sweep over every master, level and split setting.
    for (int sp = 0; sp < 2; sp++)
      for (int m = 0; m < N; m++)
        for (int lv = 0; lv < 8; lv++) begin
          do_reset();
          split_top = 1'(sp);
          set_lvl(m, lv);
          @(posedge clk); #1;
          req[m] = 1'b1;
          @(negedge clk);
          chk(grant == '0, "R9 no grant after one edge", int'(grant), 0);
          @(negedge clk);
          chk(grant == '0, "R9 no grant after two edges", int'(grant), 0);
          @(negedge clk);
          chk(grant == (N'(1) << m), "R9 grant after latency", int'(grant), 1 << m);
          @(posedge clk); #1;
          req[m] = 1'b0;
        end

    // R5/R6 pair sweep: order of two simultaneous requests.
    for (int sp = 0; sp < 2; sp++)
      for (int a = 0; a < N; a++)
        for (int b = 0; b < N; b++)
          for (int la = 0; la < 8; la++)
            for (int lb = 0; lb < 8; lb++) begin
              if (a == b) continue;
              do_reset();
              split_top = 1'(sp);
              set_lvl(a, la); set_lvl(b, lb);
              req[a] = 1'b1; req[b] = 1'b1;
              ea = bench_rank(bench_group(la, 1'(sp), a), 1'(sp));
              eb = bench_rank(bench_group(lb, 1'(sp), b), 1'(sp));
              if (ea < eb || (ea == eb && a < b)) begin first = a; second = b; end
              else begin first = b; second = a; end
              wait_grant(id);
              chk(id == first, "R5 R6 first grant of pair", id, first);
              wait_grant(id);
              chk(id == second, "R5 R6 second grant of pair", id, second);
            end

    // R3: controller stall holds the committed access.
    do_reset();
    split_top = 1'b0; lvl_cfg = '0;
    mc_ready = 1'b0;
    set_lvl(2, 1);
    req[2] = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(grant == '0 && !issue_valid, "R3 no issue while not ready", int'(grant), 0);
    end
    @(posedge clk); #1;
    mc_ready = 1'b1;
    @(negedge clk);
    chk(grant == 8'h04, "R3 issue on first ready cycle", int'(grant), 4);
    @(posedge clk); #1;
    req[2] = 1'b0;

    // R2: refresh outranks the committed access.
    do_reset();
    ref_req = 1'b1;
    req[6] = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(!issue_valid && ref_ack, "R2 refresh holds off access", int'(issue_valid), 0);
    end
    @(posedge clk); #1;
    mc_ready = 1'b0;
    @(negedge clk);
    chk(!ref_ack, "R2 ack follows ready", int'(ref_ack), 0);
    @(posedge clk); #1;
    mc_ready = 1'b1; ref_req = 1'b0;
    @(negedge clk);
    chk(grant == 8'h40, "R2 access after refresh", int'(grant), 64);
    @(posedge clk); #1;
    req[6] = 1'b0;

    // R8: late top-level request behind a committed access and a queued peer.
    do_reset();
    lvl_cfg = '0;
    set_lvl(4, 2); set_lvl(5, 2); set_lvl(0, 0);
    mc_ready = 1'b0;
    req[4] = 1'b1;
    repeat (3) @(posedge clk); #1;
    req[5] = 1'b1;
    repeat (3) @(posedge clk); #1;
    req[0] = 1'b1;
    repeat (3) @(posedge clk); #1;
    mc_ready = 1'b1;
    wait_grant(id); chk(id == 4, "R8 committed access first", id, 4);
    wait_grant(id); chk(id == 0, "R8 late top request second", id, 0);
    wait_grant(id); chk(id == 5, "R8 queued peer last", id, 5);

    // R7: round-robin pointer moves past the master just picked.
    do_reset();
    for (int m = 0; m < N; m++) set_lvl(m, 2);
    req[5] = 1'b1;
    wait_grant(id); chk(id == 5, "R7 lone request", id, 5);
    req[2] = 1'b1; req[7] = 1'b1;
    wait_grant(id); chk(id == 7, "R7 pointer after 5 picks 7", id, 7);
    wait_grant(id); chk(id == 2, "R7 then wraps to 2", id, 2);

    // R10 and R7: eight same-level requests, each granted once in order.
    do_reset();
    for (int m = 0; m < N; m++) set_lvl(m, 3);
    req = '1;
    for (int k = 0; k < N; k++) begin
      wait_grant(id);
      chk(id == k, "R7 R10 rotation order", id, k);
    end
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk(grant == '0, "R10 no extra grant", int'(grant), 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule